// File: doc/BRIEF.md
# Sequential Hamming Nearest-Match Search

This block holds a small memory of `ROWS` binary vectors. Each vector is `SLICES` slices of `SLICE_W` bits. The row with the highest index always holds the query vector. When a search command is accepted, the block compares the query against every row whose index is below the command's limit. It walks one slice per clock through a single shared popcount tree and adds the per-slice mismatch counts into a running Hamming distance for each row.

When the walk ends, the block publishes the closest row and its distance. It can also raise a sticky wake-up interrupt, but only when the match is close enough and the row index is low enough. Because the limit is given with each command, the rows above it are free for other uses, such as intermediate vectors, while the rows below it act as stored class prototypes.

The command input is a valid/ready channel:
- `start_ready` is high only while the block is idle.
- A command is taken on a clock edge where `start_valid` and `start_ready` are both high.
- A command offered while the block is busy is held off and has no effect.

The memory write and read ports carry no handshake. Writes are accepted in every cycle, including during a search.

Top module: `hs_assoc_search`

## Requirements
- R1: After reset, `busy`, `done` and `irq` are 0, `start_ready` is 1, `best_idx` is 0, `best_dist` is all ones, and every memory bit reads 0.
- R2: The query is always row `ROWS-1`. A row's distance is the number of differing bits between that row and the query, summed over all `SLICES` slices.
- R3: Only rows with an index strictly below the accepted limit are candidates. After the search, `best_idx` is the candidate with the smallest distance and `best_dist` is that distance.
- R4: When two candidates have the same distance, the lower index is reported.
- R5: For a limit L > 0, timing is as follows:
  - `busy` is high for exactly L*SLICES+1 cycles, starting in the cycle after acceptance.
  - `done` is a one-cycle pulse in the first cycle in which `busy` is low again.
  - `start_ready` equals not `busy`, so commands offered while busy are ignored.
- R6: A limit of 0 gives a `done` pulse in the cycle after acceptance. `busy` never rises, `best_dist` becomes all ones, `best_idx` becomes 0, and `irq` is not raised.
- R7: When `done` pulses after a search with a limit above 0, `irq` is set only if `best_dist <= dist_thr` and `best_idx <= idx_thr`. Both thresholds are captured when the command is accepted.
- R8: Once set, `irq` stays 1 until a cycle with `irq_clear` high. If a new raise and a clear fall on the same edge, the raise wins.
- R9: `wr_row_oh` is a one-hot row select (bit r selects row r). On the clock edge, `wr_data` is written to slice `wr_slice` of the selected row. An all-zero select writes nothing. Writes are accepted while `busy` is high.
- R10: `rd_data` shows slice `rd_slice` of row `rd_row` one cycle after the address is presented. If the same location is written on that edge, `rd_data` shows the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_row_oh | input | ROWS (8) | One-hot row select for the write port |
| wr_slice | input | SL_W (1) | Slice index for the write port |
| wr_data | input | SLICE_W (16) | Write data |
| rd_row | input | IDX_W (3) | Row index for the read port |
| rd_slice | input | SL_W (1) | Slice index for the read port |
| rd_data | output | SLICE_W (16) | Registered read data |
| start_valid | input | 1 | A search command is offered |
| start_ready | output | 1 | The block can accept a command (idle) |
| start_limit | input | IDX_W (3) | Search only rows with an index below this value |
| dist_thr | input | DIST_W (6) | Largest distance allowed to raise the interrupt |
| idx_thr | input | IDX_W (3) | Largest index allowed to raise the interrupt |
| irq_clear | input | 1 | Clears a pending interrupt |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle pulse at the end of a command |
| best_idx | output | IDX_W (3) | Index of the closest row |
| best_dist | output | DIST_W (6) | Hamming distance of the closest row |
| irq | output | 1 | Sticky wake-up interrupt |

## Verification
The assertions assume the following about the inputs:
- The write select is never more than one-hot.
- A search result only has meaning if no write touches the query row or any candidate row while the search runs.

The stimulus keeps to these rules:
- It drives the write select one row at a time.
- It writes during a search only to rows at or above the limit that are not the query row.
- It holds the thresholds steady around acceptance.

Within these bounds, a behavioural model in the bench predicts the handshake, the busy and done timing, the interrupt, the read data and the final result in every cycle.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/hs_popcount.sv
module hs_popcount #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 6
) (
  input  logic [IN_W-1:0]  vec,
  output logic [OUT_W-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < IN_W; i++) cnt = cnt + OUT_W'(vec[i]);
  end
endmodule

// File: rtl/hs_vecmem.sv
module hs_vecmem #(
  parameter int ROWS    = 8,
  parameter int SLICES  = 2,
  parameter int SLICE_W = 16,
  parameter int IDX_W   = 3,
  parameter int SL_W    = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ROWS-1:0]    wr_row_oh,
  input  logic [SL_W-1:0]    wr_slice,
  input  logic [SLICE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_row,
  input  logic [SL_W-1:0]    rd_slice,
  output logic [SLICE_W-1:0] rd_data,
  input  logic [IDX_W-1:0]   cand_row,
  input  logic [SL_W-1:0]    cand_slice,
  output logic [SLICE_W-1:0] cand_data,
  output logic [SLICE_W-1:0] query_data
);
  logic [SLICE_W-1:0] mem_q [ROWS][SLICES];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar s = 0; s < SLICES; s++) begin : g_slice
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q[r][s] <= '0;
        else if (wr_row_oh[r] && wr_slice == SL_W'(s)) mem_q[r][s] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= mem_q[rd_row][rd_slice];
  end

  assign cand_data  = mem_q[cand_row][cand_slice];
  assign query_data = mem_q[ROWS-1][cand_slice];

  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_row_oh)); // R9
endmodule

// File: rtl/hs_search_ctrl.sv
module hs_search_ctrl
  import hs_pkg::*;
#(
  parameter int SLICES = 2,
  parameter int IDX_W  = 3,
  parameter int SL_W   = 1,
  parameter int DIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [IDX_W-1:0]  start_limit,
  input  logic [DIST_W-1:0] dist_thr,
  input  logic [IDX_W-1:0]  idx_thr,
  input  logic              irq_clear,
  input  logic [DIST_W-1:0] slice_cnt,
  output logic [IDX_W-1:0]  cand_row,
  output logic [SL_W-1:0]   cand_slice,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  best_idx,
  output logic [DIST_W-1:0] best_dist,
  output logic              irq
);
  hs_state_e         state_q;
  logic [IDX_W-1:0]  row_q, limit_q, ithr_q;
  logic [SL_W-1:0]   slice_q;
  logic [DIST_W-1:0] acc_q, dthr_q, total;
  logic              accept, last_slice, last_row, pass;

  assign start_ready = (state_q == ST_IDLE);
  assign busy        = (state_q != ST_IDLE);
  assign accept      = start_valid && start_ready;
  assign total       = acc_q + slice_cnt;
  assign last_slice  = (slice_q == SL_W'(SLICES - 1));
  assign last_row    = (row_q == IDX_W'(limit_q - 1'b1));
  assign pass        = (best_dist <= dthr_q) && (best_idx <= ithr_q);
  assign cand_row    = row_q;
  assign cand_slice  = slice_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      row_q     <= '0;
      slice_q   <= '0;
      acc_q     <= '0;
      limit_q   <= '0;
      dthr_q    <= '0;
      ithr_q    <= '0;
      best_idx  <= '0;
      best_dist <= '1;
      done      <= 1'b0;
      irq       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state_q == ST_FIN && pass) irq <= 1'b1;
      else if (irq_clear)            irq <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          best_idx  <= '0;
          best_dist <= '1;
          row_q     <= '0;
          slice_q   <= '0;
          acc_q     <= '0;
          limit_q   <= start_limit;
          dthr_q    <= dist_thr;
          ithr_q    <= idx_thr;
          if (start_limit == '0) done <= 1'b1;
          else                   state_q <= ST_SCAN;
        end
        ST_SCAN: begin
          if (last_slice) begin
            if (total < best_dist) begin  // strict: earlier row keeps ties
              best_dist <= total;
              best_idx  <= row_q;
            end
            acc_q   <= '0;
            slice_q <= '0;
            if (last_row) state_q <= ST_FIN;
            else          row_q   <= row_q + 1'b1;
          end else begin
            acc_q   <= total;
            slice_q <= slice_q + 1'b1;
          end
        end
        ST_FIN: begin
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ROW_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN) |-> (row_q < limit_q)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R5
  AST_ZERO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && start_limit == '0) |=> (done && !busy && best_dist == '1 && !$rose(irq))); // R6
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (done && best_dist <= dthr_q && best_idx <= ithr_q)); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clear) |=> irq); // R8
endmodule

// File: rtl/hs_assoc_search.sv
module hs_assoc_search #(
  parameter int ROWS    = 8,
  parameter int SLICES  = 2,
  parameter int SLICE_W = 16,
  localparam int IDX_W  = $clog2(ROWS),
  localparam int SL_W   = (SLICES > 1) ? $clog2(SLICES) : 1,
  localparam int DIST_W = $clog2(SLICES * SLICE_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ROWS-1:0]    wr_row_oh,
  input  logic [SL_W-1:0]    wr_slice,
  input  logic [SLICE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_row,
  input  logic [SL_W-1:0]    rd_slice,
  output logic [SLICE_W-1:0] rd_data,
  input  logic               start_valid,
  output logic               start_ready,
  input  logic [IDX_W-1:0]   start_limit,
  input  logic [DIST_W-1:0]  dist_thr,
  input  logic [IDX_W-1:0]   idx_thr,
  input  logic               irq_clear,
  output logic               busy,
  output logic               done,
  output logic [IDX_W-1:0]   best_idx,
  output logic [DIST_W-1:0]  best_dist,
  output logic               irq
);
  logic [IDX_W-1:0]   cand_row;
  logic [SL_W-1:0]    cand_slice;
  logic [SLICE_W-1:0] cand_data, query_data;
  logic [DIST_W-1:0]  slice_cnt;

  hs_vecmem #(.ROWS(ROWS), .SLICES(SLICES), .SLICE_W(SLICE_W),
              .IDX_W(IDX_W), .SL_W(SL_W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .wr_row_oh(wr_row_oh), .wr_slice(wr_slice), .wr_data(wr_data),
    .rd_row(rd_row), .rd_slice(rd_slice), .rd_data(rd_data),
    .cand_row(cand_row), .cand_slice(cand_slice),
    .cand_data(cand_data), .query_data(query_data)
  );

  hs_popcount #(.IN_W(SLICE_W), .OUT_W(DIST_W)) u_pop (
    .vec(cand_data ^ query_data), .cnt(slice_cnt)
  );

  hs_search_ctrl #(.SLICES(SLICES), .IDX_W(IDX_W), .SL_W(SL_W),
                   .DIST_W(DIST_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_limit(start_limit), .dist_thr(dist_thr), .idx_thr(idx_thr),
    .irq_clear(irq_clear), .slice_cnt(slice_cnt),
    .cand_row(cand_row), .cand_slice(cand_slice),
    .busy(busy), .done(done), .best_idx(best_idx), .best_dist(best_dist),
    .irq(irq)
  );
endmodule

// File: tb/test_hs_assoc_search.sv
`timescale 1ns/1ps
module test_hs_assoc_search;
  localparam int ROWS = 8, SLICES = 2, SLICE_W = 16;
  localparam int MAXD = 63;

  logic clk = 0, rst_n = 0;
  logic [ROWS-1:0] wr_row_oh = '0;
  logic wr_slice = 0, rd_slice = 0;
  logic [15:0] wr_data = '0, rd_data;
  logic [2:0] rd_row = '0, start_limit = '0, idx_thr = '0, best_idx;
  logic [5:0] dist_thr = '0, best_dist;
  logic start_valid = 0, start_ready, irq_clear = 0, busy, done, irq;

  hs_assoc_search i_hs_assoc_search (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [15:0] mm [ROWS][SLICES];
  int m_cnt, m_bidx, m_bdist, p_idx, p_dist, m_dthr, m_ithr;
  logic m_done, m_irq;
  logic [15:0] m_rd;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int row_dist(input int r);
    return $countones({mm[r][1], mm[r][0]} ^ {mm[ROWS-1][1], mm[ROWS-1][0]});
  endfunction

  function automatic int ref_idx(input int lim);
    int bi = 0, bd = MAXD;
    for (int r = 0; r < lim; r++) if (row_dist(r) < bd) begin bd = row_dist(r); bi = r; end
    return bi;
  endfunction

  function automatic int ref_dist(input int lim);
    int bd = MAXD;
    for (int r = 0; r < lim; r++) if (row_dist(r) < bd) bd = row_dist(r);
    return bd;
  endfunction

  // behavioural model, advanced at each edge and compared 2 ns later
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_irq = 0; m_bidx = 0; m_bdist = MAXD; m_rd = '0;
      for (int r = 0; r < ROWS; r++) for (int s = 0; s < SLICES; s++) mm[r][s] = '0;
    end else begin
      bit ready_pre, raise;
      ready_pre = (m_cnt == 0);
      raise = 0;
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1; m_bidx = p_idx; m_bdist = p_dist;
          raise = (p_dist <= m_dthr) && (p_idx <= m_ithr);
        end
      end else if (ready_pre && start_valid) begin
        m_dthr = int'(dist_thr); m_ithr = int'(idx_thr);
        if (start_limit == 0) begin
          m_done = 1; m_bidx = 0; m_bdist = MAXD;
        end else begin
          p_idx = ref_idx(int'(start_limit)); p_dist = ref_dist(int'(start_limit));
          m_cnt = int'(start_limit) * SLICES + 1;
        end
      end
      if (raise) m_irq = 1; else if (irq_clear) m_irq = 0;
      m_rd = mm[rd_row][rd_slice];
      for (int r = 0; r < ROWS; r++) if (wr_row_oh[r]) mm[r][wr_slice] = wr_data;
      #2;
      chk("R5 start_ready", int'(start_ready), int'(m_cnt == 0));
      chk("R5 busy", int'(busy), int'(m_cnt > 0));
      chk("R5 done", int'(done), int'(m_done));
      chk("R8 irq", int'(irq), int'(m_irq));
      chk("R10 rd_data", int'(rd_data), int'(m_rd));
      if (m_cnt == 0) begin
        chk("R3 best_idx", int'(best_idx), m_bidx);
        chk("R3 best_dist", int'(best_dist), m_bdist);
      end
    end
  end

  task automatic wr(input int r, input int s, input logic [15:0] d);
    @(negedge clk);
    wr_row_oh = ROWS'(1) << r; wr_slice = s[0]; wr_data = d;
    @(negedge clk);
    wr_row_oh = '0;
  endtask

  task automatic wr_row(input int r, input logic [31:0] v);
    wr(r, 0, v[15:0]);
    wr(r, 1, v[31:16]);
  endtask

  task automatic rd_chk(input int r, input int s, input logic [15:0] exp, input string req);
    @(negedge clk);
    rd_row = r[2:0]; rd_slice = s[0];
    @(negedge clk);
    chk(req, int'(rd_data), int'(exp));
  endtask

  task automatic search(input int lim, input int dthr, input int ithr);
    @(negedge clk);
    start_valid = 1; start_limit = lim[2:0]; dist_thr = dthr[5:0]; idx_thr = ithr[2:0];
    @(negedge clk);
    start_valid = 0;
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
  endtask

  logic [31:0] q;
  int ei, ed, lim;

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog R5: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 ready", int'(start_ready), 1);
    chk("R1 best_dist", int'(best_dist), MAXD);
    rst_n = 1;
    rd_chk(3, 1, 16'h0000, "R1 mem zero");

    // fill and read back
    for (int r = 0; r < ROWS; r++) wr_row(r, $urandom);
    for (int r = 0; r < ROWS; r++) rd_chk(r, 1, mm[r][1], "R10 readback");
    rd_chk(9 % ROWS, 0, mm[1][0], "R9 write");

    // tie: rows 2 and 5 one bit off the query, rest fully inverted
    q = {mm[ROWS-1][1], mm[ROWS-1][0]};
    for (int r = 0; r < ROWS - 1; r++) wr_row(r, ~q);
    wr_row(2, q ^ 32'h1);
    wr_row(5, q ^ 32'h1);
    search(7, MAXD, 7);
    chk("R4 tie idx", int'(best_idx), 2);
    chk("R2 dist", int'(best_dist), 1);
    chk("R7 irq raised", int'(irq), 1);

    // limit restricts candidates; tie among inverted rows -> idx 0
    search(2, 0, 7);
    chk("R3 limit idx", int'(best_idx), 0);
    chk("R3 limit dist", int'(best_dist), 32);
    chk("R8 irq held", int'(irq), 1);
    @(negedge clk); irq_clear = 1; @(negedge clk); irq_clear = 0;
    chk("R8 irq cleared", int'(irq), 0);

    // index threshold blocks
    search(7, MAXD, 1);
    chk("R7 idx gate", int'(irq), 0);

    // limit zero
    search(0, MAXD, 7);
    chk("R6 dist", int'(best_dist), MAXD);
    chk("R6 idx", int'(best_idx), 0);
    chk("R6 irq", int'(irq), 0);

    // query row changed
    wr_row(ROWS - 1, ~q);
    search(7, MAXD, 7);
    chk("R2 query idx", int'(best_idx), 0);
    chk("R2 query dist", int'(best_dist), 0);
    @(negedge clk); irq_clear = 1; @(negedge clk); irq_clear = 0;

    // write during search, and start offered while busy
    @(negedge clk);
    start_valid = 1; start_limit = 3'd4; dist_thr = 6'd0; idx_thr = 3'd7;
    @(negedge clk);
    start_limit = 3'd1;
    wr_row_oh = ROWS'(1) << 6; wr_slice = 0; wr_data = 16'hA5C3;
    @(negedge clk);
    wr_row_oh = '0;
    @(negedge clk);
    start_valid = 0;
    chk("R5 busy during", int'(busy), 1);
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
    chk("R5 ignored start", int'(best_idx), 0);
    rd_chk(6, 0, 16'hA5C3, "R9 write while busy");
    repeat (3) @(negedge clk);
    chk("R5 idle after", int'(busy), 0);

    // random rounds
    for (int k = 0; k < 20; k++) begin
      for (int r = 0; r < ROWS; r++) wr_row(r, $urandom);
      lim = 1 + ($urandom % 7);
      ei = ref_idx(lim); ed = ref_dist(lim);
      search(lim, $urandom % 20, $urandom % 8);
      chk("R3 rand idx", int'(best_idx), ei);
      chk("R3 rand dist", int'(best_dist), ed);
      @(negedge clk); irq_clear = 1; @(negedge clk); irq_clear = 0;
    end

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule